// File: doc/BRIEF.md
# Multiplexed Video Bus Transmitter

This block sits at the pixel end of a display pipeline and drives a narrow, time-multiplexed video bus toward an external converter. Upstream logic offers one request per pixel slot. A request carries a red, green and blue code, four active-low sync flags (composite, horizontal, clamp, vertical) and a flag that says whether the slot is visible picture or blanking. The block serialises the request onto a bus that runs at four times the pixel rate. It also drives an active-low strobe that marks the start of each frame.

For a visible pixel, the block sends one control word with the strobe low and then three colour words with the strobe high. For a blanking slot, it sends a single control word. The block then takes the next request on the following bus clock, so during blanking the strobe stays low and the sync lines can change on any bus clock. A ready output paces the source. New input is taken only at a frame boundary, so a change of mode can never cut a pixel short.

Top module: `vbus_tx`

## Requirements
- R1: In the first cycle after reset, `bus_data` is 7'h0F (all four sync flags inactive, upper bits zero), `bus_strobe_n` is 0 and `in_ready` is 1.
- R2: A control word places composite sync on bit 0, horizontal sync on bit 1, clamp on bit 2 and vertical sync on bit 3, all copied at their active-low levels, with bits 6..4 at zero. Every control word appears with `bus_strobe_n` = 0.
- R3: A request accepted with `in_active` = 1 produces, on the four following bus clocks, the control word, then red, then green, then blue. `bus_strobe_n` is high for the three colour words.
- R4: A request accepted with `in_active` = 0 produces one control word on the next bus clock, and `in_ready` is 1 again in that same cycle. Back-to-back blanking requests therefore give control words on consecutive clocks with the strobe held low.
- R5: While a visible pixel is being sent, `in_ready` is 1 in only one cycle of each four, so back-to-back pixels take exactly four bus clocks each.
- R6: Colour, sync and mode inputs are captured only on the cycle where `in_valid` and `in_ready` are both 1. Input changes while `in_ready` is 0 do not affect the words being sent.
- R7: A request offered while `in_ready` is 0 is not taken. A switch between blanking and visible output therefore happens only after the blue word of the current pixel.
- R8: When `in_ready` is 1 and `in_valid` is 0, the next bus word repeats the last control word with the strobe low. After reset, the repeated word is the all-inactive word from R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock (four times the pixel rate) |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request will be taken at the next edge |
| in_active | input | 1 | 1 = visible pixel, 0 = blanking slot |
| in_red | input | COLOR_W | Red code |
| in_green | input | COLOR_W | Green code |
| in_blue | input | COLOR_W | Blue code |
| in_csync_n | input | 1 | Composite sync, active low |
| in_hsync_n | input | 1 | Horizontal sync, active low |
| in_clamp_n | input | 1 | Clamp / burst gate, active low |
| in_vsync_n | input | 1 | Vertical sync, active low |
| bus_data | output | COLOR_W | Multiplexed bus word |
| bus_strobe_n | output | 1 | Active-low frame strobe, low on control words |

## Verification
The bench builds the block with its default colour width of 7. At that width the bus word and a colour code have the same size, so every colour code from 0 to 127 reaches the bus unchanged, and all sixteen sync-flag combinations fit beside the three zero bits of the control word. The seeded random mix of visible, blanking and idle slots lands mode changes and mid-frame input changes in every phase of the four-word frame. Directed runs add reset, back-to-back pixels and long blanking stretches.

// File: rtl/vbus_pkg.sv
package vbus_pkg;

    // Number of sync flags carried in a control word
    localparam int SYNC_W      = 4;
    // Colour words that follow a control word: red, green, blue
    localparam int COLOR_WORDS = 3;

    // Packed so that bit 0 = composite, 1 = horizontal, 2 = clamp, 3 = vertical
    typedef struct packed {
        logic vsync_n;
        logic clamp_n;
        logic hsync_n;
        logic csync_n;
    } sync_t;

    localparam sync_t SYNC_IDLE = '{vsync_n: 1'b1, clamp_n: 1'b1,
                                    hsync_n: 1'b1, csync_n: 1'b1};

    typedef enum logic {
        WORD_CTRL  = 1'b0,
        WORD_COLOR = 1'b1
    } word_kind_e;

    function automatic sync_t pack_sync(input logic cs_n, input logic hs_n,
                                        input logic cl_n, input logic vs_n);
        sync_t s;
        s.csync_n = cs_n;
        s.hsync_n = hs_n;
        s.clamp_n = cl_n;
        s.vsync_n = vs_n;
        return s;
    endfunction

endpackage

// File: rtl/vbus_seq_ctrl.sv
module vbus_seq_ctrl
    import vbus_pkg::*;
#(
    parameter int COLOR_WORDS_P = COLOR_WORDS,
    localparam int CNT_W        = $clog2(COLOR_WORDS_P + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_active,
    output logic             ready,
    output logic             accept,
    output word_kind_e       next_kind,
    output logic [CNT_W-1:0] color_idx
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(COLOR_WORDS_P);

    logic [CNT_W-1:0] left_q;

    assign ready     = (left_q == '0);
    assign accept    = ready && in_valid;
    assign next_kind = ready ? WORD_CTRL : WORD_COLOR;
    assign color_idx = FULL - left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (accept) begin
            left_q <= in_active ? FULL : '0;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

endmodule

// File: rtl/vbus_capture.sv
module vbus_capture
    import vbus_pkg::*;
#(
    parameter int COLOR_W       = 7,
    parameter int COLOR_WORDS_P = COLOR_WORDS
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  accept,
    input  sync_t                                 sync_in,
    input  logic [COLOR_WORDS_P-1:0][COLOR_W-1:0] colors_in,
    output sync_t                                 sync_held,
    output logic [COLOR_WORDS_P-1:0][COLOR_W-1:0] colors_held
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_held <= SYNC_IDLE;
        end else if (accept) begin
            sync_held <= sync_in;
        end
    end

    for (genvar i = 0; i < COLOR_WORDS_P; i++) begin : g_col
        always_ff @(posedge clk) begin
            if (rst) begin
                colors_held[i] <= '0;
            end else if (accept) begin
                colors_held[i] <= colors_in[i];
            end
        end
    end

endmodule

// File: rtl/vbus_word_sel.sv
module vbus_word_sel
    import vbus_pkg::*;
#(
    parameter int COLOR_W       = 7,
    parameter int COLOR_WORDS_P = COLOR_WORDS,
    localparam int CNT_W        = $clog2(COLOR_WORDS_P + 1)
) (
    input  word_kind_e                            kind,
    input  logic [CNT_W-1:0]                      color_idx,
    input  sync_t                                 sync_src,
    input  logic [COLOR_WORDS_P-1:0][COLOR_W-1:0] colors,
    output logic [COLOR_W-1:0]                    word,
    output logic                                  strobe_n
);

    localparam int PAD_W = COLOR_W - SYNC_W;

    logic [COLOR_W-1:0] ctrl_word;
    logic [COLOR_W-1:0] color_word;

    assign ctrl_word = {{PAD_W{1'b0}}, sync_src};

    always_comb begin
        color_word = '0;
        for (int i = 0; i < COLOR_WORDS_P; i++) begin
            if (color_idx == CNT_W'(i)) begin
                color_word = colors[i];
            end
        end
    end

    always_comb begin
        unique case (kind)
            WORD_CTRL: begin
                word     = ctrl_word;
                strobe_n = 1'b0;
            end
            WORD_COLOR: begin
                word     = color_word;
                strobe_n = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/vbus_tx.sv
module vbus_tx
    import vbus_pkg::*;
#(
    parameter int COLOR_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_active,
    input  logic [COLOR_W-1:0] in_red,
    input  logic [COLOR_W-1:0] in_green,
    input  logic [COLOR_W-1:0] in_blue,
    input  logic               in_csync_n,
    input  logic               in_hsync_n,
    input  logic               in_clamp_n,
    input  logic               in_vsync_n,
    output logic [COLOR_W-1:0] bus_data,
    output logic               bus_strobe_n
);

    localparam int CNT_W = $clog2(COLOR_WORDS + 1);
    localparam logic [COLOR_W-1:0] IDLE_WORD = {{(COLOR_W - SYNC_W){1'b0}}, SYNC_IDLE};

    logic                                accept;
    word_kind_e                          next_kind;
    logic [CNT_W-1:0]                    color_idx;
    sync_t                               sync_now;
    sync_t                               sync_held;
    sync_t                               sync_src;
    logic [COLOR_WORDS-1:0][COLOR_W-1:0] colors_now;
    logic [COLOR_WORDS-1:0][COLOR_W-1:0] colors_held;
    logic [COLOR_W-1:0]                  word_d;
    logic                                strobe_d;

    assign sync_now   = pack_sync(in_csync_n, in_hsync_n, in_clamp_n, in_vsync_n);
    // index 0 is sent first
    assign colors_now = {in_blue, in_green, in_red};
    assign sync_src   = accept ? sync_now : sync_held;

    vbus_seq_ctrl #(.COLOR_WORDS_P(COLOR_WORDS)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_active (in_active),
        .ready     (in_ready),
        .accept    (accept),
        .next_kind (next_kind),
        .color_idx (color_idx)
    );

    vbus_capture #(.COLOR_W(COLOR_W), .COLOR_WORDS_P(COLOR_WORDS)) cap_i (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .sync_in     (sync_now),
        .colors_in   (colors_now),
        .sync_held   (sync_held),
        .colors_held (colors_held)
    );

    vbus_word_sel #(.COLOR_W(COLOR_W), .COLOR_WORDS_P(COLOR_WORDS)) sel_i (
        .kind      (next_kind),
        .color_idx (color_idx),
        .sync_src  (sync_src),
        .colors    (colors_held),
        .word      (word_d),
        .strobe_n  (strobe_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_data     <= IDLE_WORD;
            bus_strobe_n <= 1'b0;
        end else begin
            bus_data     <= word_d;
            bus_strobe_n <= strobe_d;
        end
    end

endmodule

// File: rtl/vbus_tx_chk.sv
module vbus_tx_chk #(
    parameter int COLOR_W = 7
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic               in_active,
    input logic               in_csync_n,
    input logic               in_hsync_n,
    input logic               in_clamp_n,
    input logic               in_vsync_n,
    input logic [COLOR_W-1:0] bus_data,
    input logic               bus_strobe_n
);

    // R1
    reset_word_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bus_data == COLOR_W'(7'h0F) && !bus_strobe_n && in_ready));

    // R2
    ctrl_pad_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_strobe_n |-> (bus_data[COLOR_W-1:4] == '0));

    // R2
    ctrl_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=>
            (bus_data[3:0] == $past({in_vsync_n, in_clamp_n, in_hsync_n, in_csync_n})));

    // R3
    color_run_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_strobe_n) |=> bus_strobe_n ##1 bus_strobe_n ##1 !bus_strobe_n);

    // R4
    blank_back_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !in_active) |=> (!bus_strobe_n && in_ready));

    // R5
    busy_color_chk: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> bus_strobe_n);

    // R7
    pixel_start_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_active) |=> (!bus_strobe_n && !in_ready));

endmodule

bind vbus_tx vbus_tx_chk #(.COLOR_W(COLOR_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_active    (in_active),
    .in_csync_n   (in_csync_n),
    .in_hsync_n   (in_hsync_n),
    .in_clamp_n   (in_clamp_n),
    .in_vsync_n   (in_vsync_n),
    .bus_data     (bus_data),
    .bus_strobe_n (bus_strobe_n)
);

// File: tb/vbus_tx_tb_top.sv
`timescale 1ns/100ps
module vbus_tx_tb_top;

    localparam int CW = 7;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          in_ready;
    logic          in_active;
    logic [CW-1:0] in_red, in_green, in_blue;
    logic          in_csync_n, in_hsync_n, in_clamp_n, in_vsync_n;
    logic [CW-1:0] bus_data;
    logic          bus_strobe_n;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // reference state taken from the requirements
    int            m_left;
    logic [3:0]    m_ctrl;
    logic [CW-1:0] m_cols [3];

    always #2.5 clk = ~clk;

    vbus_tx #(.COLOR_W(CW)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_active(in_active), .in_red(in_red), .in_green(in_green),
        .in_blue(in_blue), .in_csync_n(in_csync_n), .in_hsync_n(in_hsync_n),
        .in_clamp_n(in_clamp_n), .in_vsync_n(in_vsync_n),
        .bus_data(bus_data), .bus_strobe_n(bus_strobe_n)
    );

    task automatic check(input string tag, input string what,
                         input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [CW-1:0] ctrl_word(input logic [3:0] s);
        return {{(CW-4){1'b0}}, s};
    endfunction

    // s = {vsync_n, clamp_n, hsync_n, csync_n}
    task automatic step(input string tag, input logic v, input logic act,
                        input logic [3:0] s, input logic [CW-1:0] r,
                        input logic [CW-1:0] g, input logic [CW-1:0] b);
        logic          exp_ready;
        logic [CW-1:0] exp_data;
        logic          exp_strb;
        @(negedge clk);
        in_valid   = v;
        in_active  = act;
        in_csync_n = s[0];
        in_hsync_n = s[1];
        in_clamp_n = s[2];
        in_vsync_n = s[3];
        in_red     = r;
        in_green   = g;
        in_blue    = b;
        #1;
        exp_ready = (m_left == 0);
        check(tag, "ready", CW'(in_ready), CW'(exp_ready));
        if (exp_ready && v) begin
            m_ctrl    = s;
            m_cols[0] = r;
            m_cols[1] = g;
            m_cols[2] = b;
            m_left    = act ? 3 : 0;
            exp_data  = ctrl_word(s);
            exp_strb  = 1'b0;
        end else if (m_left != 0) begin
            exp_data = m_cols[3 - m_left];
            exp_strb = 1'b1;
            m_left--;
        end else begin
            exp_data = ctrl_word(m_ctrl);
            exp_strb = 1'b0;
        end
        @(posedge clk);
        #1;
        check(tag, "bus_data", bus_data, exp_data);
        check(tag, "strobe_n", CW'(bus_strobe_n), CW'(exp_strb));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        in_valid = 0; in_active = 0;
        in_red = 0; in_green = 0; in_blue = 0;
        in_csync_n = 1; in_hsync_n = 1; in_clamp_n = 1; in_vsync_n = 1;
        m_left = 0; m_ctrl = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1", "reset bus_data", bus_data, 7'h0F);
        check("R1", "reset strobe_n", CW'(bus_strobe_n), 7'h00);
        check("R1", "reset ready", CW'(in_ready), 7'h01);

        // R8 idle keeps the all-inactive control word
        repeat (3) step("R8", 0, 1, 4'h0, 7'h55, 7'h55, 7'h55);

        // R2 single-flag patterns, R4 consecutive blanking words
        step("R2", 1, 0, 4'hE, 0, 0, 0);
        step("R2", 1, 0, 4'hD, 0, 0, 0);
        step("R2", 1, 0, 4'hB, 0, 0, 0);
        step("R2", 1, 0, 4'h7, 0, 0, 0);
        for (int i = 0; i < 16; i++) step("R4", 1, 0, 4'(i), 7'h7F, 7'h7F, 7'h7F);

        // R3 one visible pixel with distinct codes
        step("R3", 1, 1, 4'hA, 7'h11, 7'h22, 7'h33);
        // R6 mid-pixel input changes are ignored, R7 blanking request held off
        step("R6", 1, 0, 4'h0, 7'h44, 7'h45, 7'h46);
        step("R6", 1, 1, 4'h3, 7'h47, 7'h48, 7'h49);
        step("R7", 1, 0, 4'h5, 7'h4A, 7'h4B, 7'h4C);
        // R8 idle after a pixel repeats its control word
        step("R8", 0, 0, 4'h0, 0, 0, 0);
        step("R8", 0, 1, 4'h0, 0, 0, 0);

        // R5 back-to-back pixels at full-scale codes
        for (int i = 0; i < 12; i++)
            step("R5", 1, 1, 4'(i + 3), (i % 2) ? 7'h7F : 7'h00, 7'(i), 7'h7F - 7'(i));

        // R7 blanking right after a pixel, then back to visible
        step("R7", 1, 0, 4'h6, 0, 0, 0);
        step("R7", 1, 1, 4'h9, 7'h01, 7'h02, 7'h03);
        repeat (3) step("R7", 1, 0, 4'h0, 7'h70, 7'h71, 7'h72);
        step("R7", 1, 0, 4'hC, 0, 0, 0);

        // R6 seeded random mix of valid, mode, sync and colour
        for (int i = 0; i < 3000; i++)
            step("R6", ($urandom % 4) != 0, $urandom % 2, 4'($urandom),
                 7'($urandom), 7'($urandom), 7'($urandom));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule